// File: doc/BRIEF.md
# Raster Timing Generator with Frame Flush

This block produces the scan timing for a small parallel-RGB panel from its own pixel clock. A horizontal counter sweeps each line through four segments (visible pixels, front porch, sync pulse, back porch). A vertical counter does the same over lines. From these counters the block drives horizontal and vertical sync, a data-enable strobe and the current pixel coordinates. It also issues a pop strobe to a read FIFO for each visible pixel. The counters are free-running and take no input from the memory side.

Every frame must begin at framebuffer address zero. To ensure this, the block raises a flush request as soon as the last visible pixel of a frame has been shown. The memory side uses that request to stop fetching, empty the read FIFO and rewind its read address. The request drops at the start of the last blanking line, which leaves one full line time for the FIFO to refill before the first visible line. The pixel clock and the memory clock may be unrelated. A copy of the flush request is therefore brought into the memory clock domain through a two-flop synchronizer. After reset the scan starts at the first pixel of the last blanking line, so the first frame also gets a refill line.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, and in the state it leaves, the position is x = 0, y = V_TOTAL-1, `de_o` and `fifo_pop_o` are 0, both syncs are at their idle level and `flush_o` is 0.
- R2: `px_x_o` rises by one on every pixel clock and returns to 0 after H_TOTAL-1. `px_y_o` changes only when x wraps, rises by one and returns to 0 after V_TOTAL-1. Here H_TOTAL = H_ACTIVE+H_FRONT+H_SYNC+H_BACK, and V_TOTAL is formed the same way.
- R3: `de_o` is 1 exactly when x < H_ACTIVE and y < V_ACTIVE.
- R4: `fifo_pop_o` equals `de_o` on every cycle, so one frame issues exactly H_ACTIVE*V_ACTIVE pops.
- R5: The horizontal sync is asserted for H_ACTIVE+H_FRONT <= x < H_ACTIVE+H_FRONT+H_SYNC. `hsync_o` is low while asserted when HS_LOW = 1, and high while asserted when HS_LOW = 0.
- R6: The vertical sync is asserted on whole lines V_ACTIVE+V_FRONT <= y < V_ACTIVE+V_FRONT+V_SYNC. VS_LOW sets its polarity in the same way.
- R7: `flush_o` rises in the cycle whose position is x = H_ACTIVE, y = V_ACTIVE-1, which is the pixel right after the last visible one.
- R8: `flush_o` falls in the cycle whose position is x = 0, y = V_TOTAL-1, and stays 0 through the whole visible area.
- R9: `mem_flush_o` is `flush_o` resampled by two `mem_clk` flops. It is 0 while `mem_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset, pixel domain |
| mem_clk | input | 1 | Memory-side clock |
| mem_rst | input | 1 | Synchronous active-high reset, memory domain |
| px_x_o | output | HW | Current pixel column |
| px_y_o | output | VW | Current line |
| de_o | output | 1 | Data enable, visible area |
| hsync_o | output | 1 | Horizontal sync, polarity set by HS_LOW |
| vsync_o | output | 1 | Vertical sync, polarity set by VS_LOW |
| fifo_pop_o | output | 1 | Read strobe to the pixel FIFO |
| flush_o | output | 1 | Frame flush request, pixel domain |
| mem_flush_o | output | 1 | Flush request synchronized to mem_clk |

## Verification
Every output is a flop loaded from the next counter value, so a wrong counter or segment decode appears at the ports in the same cycle the counter goes wrong. A step error in x displaces `de_o` and the sync pulse within the first line after reset. A wrong vertical decode appears within one frame. A flush flop that sets or clears at the wrong position shifts the `flush_o` edges against the coordinates within one frame, and the pop count per frame exposes any mismatch between the pop strobe and the visible area.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [1:0] {
    SEG_ACTIVE = 2'd0,
    SEG_FRONT  = 2'd1,
    SEG_SYNC   = 2'd2,
    SEG_BACK   = 2'd3
  } seg_e;

  // Segment of a position along one axis: visible, front porch, sync, back porch.
  function automatic seg_e seg_of(input int unsigned pos,
                                  input int unsigned act,
                                  input int unsigned fp,
                                  input int unsigned sw);
    if (pos < act)                return SEG_ACTIVE;
    else if (pos < act + fp)      return SEG_FRONT;
    else if (pos < act + fp + sw) return SEG_SYNC;
    else                          return SEG_BACK;
  endfunction

endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
#(
  parameter int ACT     = 320,
  parameter int FP      = 20,
  parameter int SW      = 30,
  parameter int TOTAL   = 408,
  parameter int RST_VAL = 0,
  parameter int W       = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         last,
  output seg_e         seg_nxt
);

  assign last = (cnt_q == W'(TOTAL - 1));

  // Next count folds reset in, so that every register loaded from it
  // lands on the reset position together with the counter.
  always_comb begin
    if (rst)        cnt_nxt = W'(RST_VAL);
    else if (!step) cnt_nxt = cnt_q;
    else if (last)  cnt_nxt = '0;
    else            cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
  end

  assign seg_nxt = seg_of(32'(cnt_nxt), ACT, FP, SW);

  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(TOTAL - 1))
    else $error("axis counter beyond total");

endmodule

// File: rtl/rtg_flush_ctl.sv
module rtg_flush_ctl #(
  parameter int WX    = 9,
  parameter int WY    = 9,
  parameter int SET_X = 320,
  parameter int SET_Y = 239,
  parameter int CLR_X = 0,
  parameter int CLR_Y = 261
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WX-1:0] x_nxt,
  input  logic [WY-1:0] y_nxt,
  output logic          flush_q
);

  logic set_hit;
  logic clr_hit;

  assign set_hit = (x_nxt == WX'(SET_X)) && (y_nxt == WY'(SET_Y));
  assign clr_hit = (x_nxt == WX'(CLR_X)) && (y_nxt == WY'(CLR_Y));

  always_ff @(posedge clk) begin
    if (rst)          flush_q <= 1'b0;
    else if (set_hit) flush_q <= 1'b1;
    else if (clr_hit) flush_q <= 1'b0;
  end

  a_r7_no_double_set: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> !set_hit)
    else $error("flush set while already pending");

endmodule

// File: rtl/rtg_sync2.sv
module rtg_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int H_ACTIVE = 320,
  parameter int H_FRONT  = 20,
  parameter int H_SYNC   = 30,
  parameter int H_BACK   = 38,
  parameter int V_ACTIVE = 240,
  parameter int V_FRONT  = 4,
  parameter int V_SYNC   = 3,
  parameter int V_BACK   = 15,
  parameter bit HS_LOW   = 1'b1,
  parameter bit VS_LOW   = 1'b1,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_clk,
  input  logic          mem_rst,
  output logic [HW-1:0] px_x_o,
  output logic [VW-1:0] px_y_o,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          fifo_pop_o,
  output logic          flush_o,
  output logic          mem_flush_o
);

  logic [HW-1:0] x_nxt;
  logic [VW-1:0] y_nxt;
  logic          x_last;
  logic          y_last;
  seg_e          x_seg;
  seg_e          y_seg;
  logic          vis_nxt;

  rtg_axis #(
    .ACT(H_ACTIVE), .FP(H_FRONT), .SW(H_SYNC), .TOTAL(H_TOTAL),
    .RST_VAL(0), .W(HW)
  ) u_haxis (
    .clk(clk), .rst(rst), .step(1'b1),
    .cnt_q(px_x_o), .cnt_nxt(x_nxt), .last(x_last), .seg_nxt(x_seg)
  );

  rtg_axis #(
    .ACT(V_ACTIVE), .FP(V_FRONT), .SW(V_SYNC), .TOTAL(V_TOTAL),
    .RST_VAL(V_TOTAL - 1), .W(VW)
  ) u_vaxis (
    .clk(clk), .rst(rst), .step(x_last),
    .cnt_q(px_y_o), .cnt_nxt(y_nxt), .last(y_last), .seg_nxt(y_seg)
  );

  assign vis_nxt = (x_seg == SEG_ACTIVE) && (y_seg == SEG_ACTIVE);

  // Outputs are loaded from the next position, aligned with the counters.
  always_ff @(posedge clk) begin
    de_o       <= vis_nxt;
    fifo_pop_o <= vis_nxt;
    hsync_o    <= (x_seg == SEG_SYNC) ^ HS_LOW;
    vsync_o    <= (y_seg == SEG_SYNC) ^ VS_LOW;
  end

  rtg_flush_ctl #(
    .WX(HW), .WY(VW),
    .SET_X(H_ACTIVE), .SET_Y(V_ACTIVE - 1),
    .CLR_X(0),        .CLR_Y(V_TOTAL - 1)
  ) u_flush (
    .clk(clk), .rst(rst), .x_nxt(x_nxt), .y_nxt(y_nxt), .flush_q(flush_o)
  );

  rtg_sync2 #(.STAGES(2)) u_msync (
    .clk(mem_clk), .rst(mem_rst), .d(flush_o), .q(mem_flush_o)
  );

  a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
    (px_x_o != HW'(H_TOTAL - 1)) |=> (px_x_o == HW'($past(px_x_o) + 1'b1)))
    else $error("x did not advance");

  a_r2_x_wrap: assert property (@(posedge clk) disable iff (rst)
    (px_x_o == HW'(H_TOTAL - 1)) |=> (px_x_o == '0))
    else $error("x did not wrap");

  a_r2_y_hold: assert property (@(posedge clk) disable iff (rst)
    !x_last |=> $stable(px_y_o))
    else $error("y moved mid-line");

  a_r2_y_wrap: assert property (@(posedge clk) disable iff (rst)
    (x_last && y_last) |=> (px_y_o == '0))
    else $error("y did not wrap");

  a_r3_de_visible: assert property (@(posedge clk) disable iff (rst)
    de_o |-> ((px_x_o < HW'(H_ACTIVE)) && (px_y_o < VW'(V_ACTIVE))))
    else $error("de outside visible area");

  a_r4_pop_matches_de: assert property (@(posedge clk) disable iff (rst)
    fifo_pop_o == de_o)
    else $error("pop differs from de");

  a_r7_flush_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(flush_o) |-> ((px_x_o == HW'(H_ACTIVE)) && (px_y_o == VW'(V_ACTIVE - 1))))
    else $error("flush rose at wrong position");

  a_r8_flush_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(flush_o) |-> ((px_x_o == '0) && (px_y_o == VW'(V_TOTAL - 1))))
    else $error("flush fell at wrong position");

  a_r8_no_flush_visible: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !flush_o)
    else $error("flush during visible pixel");

endmodule

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/100ps
module raster_timing_gen_tb_top;

  localparam int HA = 6, HF = 2, HS = 2, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);

  logic clk = 1'b0;
  logic mem_clk = 1'b0;
  logic rst = 1'b1;
  logic mem_rst = 1'b1;
  logic [HW-1:0] px_x;
  logic [VW-1:0] px_y;
  logic de, hs, vs, pop, fl, mfl;

  always #5 clk = ~clk;
  always #3.5 mem_clk = ~mem_clk;

  raster_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .HS_LOW(1'b1), .VS_LOW(1'b0)
  ) dut_i (
    .clk(clk), .rst(rst), .mem_clk(mem_clk), .mem_rst(mem_rst),
    .px_x_o(px_x), .px_y_o(px_y), .de_o(de), .hsync_o(hs), .vsync_o(vs),
    .fifo_pop_o(pop), .flush_o(fl), .mem_flush_o(mfl)
  );

  // {n, x, y, de, hsync, vsync, flush}; n = edges since reset release.
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {8'd0,   4'd0,  4'd8, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd5,   4'd5,  4'd8, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd12,  4'd0,  4'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd17,  4'd5,  4'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd18,  4'd6,  4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd20,  4'd8,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd21,  4'd9,  4'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'd22,  4'd10, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd53,  4'd5,  4'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'd54,  4'd6,  4'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'd72,  4'd0,  4'd5, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'd96,  4'd0,  4'd7, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'd107, 4'd11, 4'd7, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'd108, 4'd0,  4'd8, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'd120, 4'd0,  4'd0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference position and levels from the requirements.
  task automatic model_check(input int n);
    int l  = ((VT - 1) * HT + n) % FT;
    int ex = l % HT;
    int ey = l / HT;
    bit ede = (ex < HA) && (ey < VA);
    bit ehs = !((ex >= HA + HF) && (ex < HA + HF + HS));
    bit evs = (ey >= VA + VF) && (ey < VA + VF + VS);
    bit efl = (l >= (VA - 1) * HT + HA) && (l < (VT - 1) * HT);
    chk(int'(px_x) == ex && int'(px_y) == ey, "R2 position", int'(px_x) * 100 + int'(px_y), ex * 100 + ey);
    chk(de == ede, "R3 de", int'(de), int'(ede));
    chk(pop == de, "R4 pop vs de", int'(pop), int'(de));
    chk(hs == ehs, "R5 hsync", int'(hs), int'(ehs));
    chk(vs == evs, "R6 vsync", int'(vs), int'(evs));
    if (efl) chk(fl == efl, "R7 flush set", int'(fl), int'(efl));
    else     chk(fl == efl, "R8 flush clear", int'(fl), int'(efl));
  endtask

  initial begin
    int pops = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mem_rst = 1'b0;
    for (int n = 0; n <= 170; n++) begin
      model_check(n);
      for (int k = 0; k < NV; k++) begin
        if (int'(VEC[k][19:12]) == n) begin
          chk({px_x, px_y} == VEC[k][11:4], (n == 0) ? "R1 reset position" : "R2 table position",
              int'({px_x, px_y}), int'(VEC[k][11:4]));
          chk(de == VEC[k][3], (n == 0) ? "R1 reset de" : "R3 table de", int'(de), int'(VEC[k][3]));
          chk(hs == VEC[k][2], "R5 table hsync", int'(hs), int'(VEC[k][2]));
          chk(vs == VEC[k][1], "R6 table vsync", int'(vs), int'(VEC[k][1]));
          chk(fl == VEC[k][0], "R7/R8 table flush", int'(fl), int'(VEC[k][0]));
        end
      end
      if (n >= 12 && n < 12 + FT && pop) pops++;
      if (n == 50)  chk(mfl == 1'b0, "R9 mem flush idle", int'(mfl), 0);
      if (n == 60)  chk(mfl == 1'b1, "R9 mem flush set", int'(mfl), 1);
      if (n == 112) chk(mfl == 1'b0, "R9 mem flush clear", int'(mfl), 0);
      @(negedge clk);
    end
    chk(pops == HA * VA, "R4 pops per frame", pops, HA * VA);
    // n = 171 here: flush pending; reset must clear everything.
    chk(fl == 1'b1, "R7 flush pending before reset", int'(fl), 1);
    rst = 1'b1;
    @(negedge clk);
    chk(int'(px_x) == 0 && int'(px_y) == VT - 1, "R1 reset position mid-run", int'(px_x) * 100 + int'(px_y), VT - 1);
    chk(de == 1'b0 && pop == 1'b0, "R1 reset de/pop", int'({de, pop}), 0);
    chk(hs == 1'b1 && vs == 1'b0, "R1 reset sync idle", int'({hs, vs}), 2);
    chk(fl == 1'b0, "R1 reset flush", int'(fl), 0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(int'(px_x) == 0 && int'(px_y) == 0 && de, "R2 restart first pixel", int'(px_x) * 100 + int'(px_y), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule